// File: doc/BRIEF.md
# Thread identity and counter CSR unit

This block is the control-register file of one core in a processor that runs several warps, each with several threads. Each read request carries a register address plus the index of the requesting thread and warp. Identity registers are not stored. They are worked out from the requester's indices, the core number and the fixed configuration parameters. So every thread reads its own IDs at warp, core and processor scope from the same address.

Two 64-bit counters are kept. One counts clock cycles and the other counts retired instructions. Each is exposed as a low half and a high half at separate read-only addresses. Every other address belongs to a writable general register array, indexed by the low address bits. Read data is decoded combinationally from the request inputs and registered, so a result appears one clock after the request. Writes to the array take effect at the clock edge.

Top module: `csr_ident_unit`

## Requirements
- R1: Reset is asynchronous and active low. It clears the read data output to 0 and clears every general array entry to 0. It loads the cycle counter with CYC_INIT and the retired counter with RET_INIT (both 0 by default).
- R2: A read request sampled at a rising edge appears on rd_data_o after that edge and holds until the next edge. Reading address 0xCC0 returns the requesting tid.
- R3: Address 0xCC1 returns tid + wid*THREADS. Address 0xCC2 returns tid + wid*THREADS + THREADS*WARPS*core_id.
- R4: Address 0xCC3 returns wid. Address 0xCC4 returns wid + WARPS*core_id. Address 0xCC5 returns core_id.
- R5: Addresses 0xFC0, 0xFC1 and 0xFC2 return THREADS, WARPS and NUM_CORES.
- R6: The 64-bit cycle counter adds one on every clock edge out of reset. Address 0xC00 reads bits 31:0 and address 0xC80 reads bits 63:32, including the carry across the halves.
- R7: The 64-bit retired counter adds one on each edge where retire_i is high. Address 0xC02 reads bits 31:0 and address 0xC82 reads bits 63:32. A read in the same cycle as a pulse returns the count before that pulse.
- R8: Any other address reads and writes general entry (address mod GEN_DEPTH). A write becomes visible to reads from the next cycle. A read of the same entry in the write cycle returns the old value.
- R9: Writes to any of the thirteen read-only addresses listed in R2 to R7 are ignored. They change neither what that address reads nor any general array entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_id_i | input | CID_W | Number of this core |
| rd_addr_i | input | 12 | Read register address |
| rd_tid_i | input | TID_W | Requesting thread index within its warp |
| rd_wid_i | input | WID_W | Requesting warp index within the core |
| rd_data_o | output | XLEN | Registered read data |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 12 | Write register address |
| wr_data_i | input | XLEN | Write data |
| retire_i | input | 1 | One pulse per retired instruction |

## Verification
The bench builds the unit with 4 threads per warp, 8 warps and 4 cores, and drives core number 3. With these values the three terms of the global thread ID stay apart, and a mistake in any stride or factor shows up in the result. CYC_INIT is set to 0xFFFF_FFF0 and RET_INIT to 0xFFFF_FFFE. This brings the carry into both upper halves within a few tens of cycles, where the default zero start would need 2^32 cycles. A 16-entry general array allows aliased addresses and an ignored write to index 0 to be checked against a stored value.

// File: rtl/csr_ident_pkg.sv
package csr_ident_pkg;

    localparam int CSR_AW = 12;

    // counter halves
    localparam logic [CSR_AW-1:0] A_CYC_LO      = 12'hC00;
    localparam logic [CSR_AW-1:0] A_RET_LO      = 12'hC02;
    localparam logic [CSR_AW-1:0] A_CYC_HI      = 12'hC80;
    localparam logic [CSR_AW-1:0] A_RET_HI      = 12'hC82;
    // identity values derived from the requester
    localparam logic [CSR_AW-1:0] A_THR_IN_WARP = 12'hCC0;
    localparam logic [CSR_AW-1:0] A_THR_IN_CORE = 12'hCC1;
    localparam logic [CSR_AW-1:0] A_THR_GLOBAL  = 12'hCC2;
    localparam logic [CSR_AW-1:0] A_WARP_LOCAL  = 12'hCC3;
    localparam logic [CSR_AW-1:0] A_WARP_GLOBAL = 12'hCC4;
    localparam logic [CSR_AW-1:0] A_CORE_IDX    = 12'hCC5;
    // configuration constants
    localparam logic [CSR_AW-1:0] A_CFG_THREADS = 12'hFC0;
    localparam logic [CSR_AW-1:0] A_CFG_WARPS   = 12'hFC1;
    localparam logic [CSR_AW-1:0] A_CFG_CORES   = 12'hFC2;

    typedef enum logic [3:0] {
        SEL_GENERIC,
        SEL_CYC_LO,
        SEL_CYC_HI,
        SEL_RET_LO,
        SEL_RET_HI,
        SEL_THR_IN_WARP,
        SEL_THR_IN_CORE,
        SEL_THR_GLOBAL,
        SEL_WARP_LOCAL,
        SEL_WARP_GLOBAL,
        SEL_CORE_IDX,
        SEL_CFG_THREADS,
        SEL_CFG_WARPS,
        SEL_CFG_CORES
    } csr_sel_e;

    typedef struct packed {
        logic [63:0] cycle;
        logic [63:0] instret;
    } ctr_state_t;

    function automatic csr_sel_e csr_decode(input logic [CSR_AW-1:0] a);
        csr_sel_e s;
        case (a)
            A_CYC_LO:      s = SEL_CYC_LO;
            A_CYC_HI:      s = SEL_CYC_HI;
            A_RET_LO:      s = SEL_RET_LO;
            A_RET_HI:      s = SEL_RET_HI;
            A_THR_IN_WARP: s = SEL_THR_IN_WARP;
            A_THR_IN_CORE: s = SEL_THR_IN_CORE;
            A_THR_GLOBAL:  s = SEL_THR_GLOBAL;
            A_WARP_LOCAL:  s = SEL_WARP_LOCAL;
            A_WARP_GLOBAL: s = SEL_WARP_GLOBAL;
            A_CORE_IDX:    s = SEL_CORE_IDX;
            A_CFG_THREADS: s = SEL_CFG_THREADS;
            A_CFG_WARPS:   s = SEL_CFG_WARPS;
            A_CFG_CORES:   s = SEL_CFG_CORES;
            default:       s = SEL_GENERIC;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/csr_id_calc.sv
module csr_id_calc #(
    parameter int XLEN      = 32,
    parameter int THREADS   = 4,
    parameter int WARPS     = 4,
    parameter int TID_W     = 2,
    parameter int WID_W     = 2,
    parameter int CID_W     = 1
) (
    input  logic [TID_W-1:0] tid_i,
    input  logic [WID_W-1:0] wid_i,
    input  logic [CID_W-1:0] cid_i,
    output logic [XLEN-1:0]  thr_in_warp_o,
    output logic [XLEN-1:0]  thr_in_core_o,
    output logic [XLEN-1:0]  thr_global_o,
    output logic [XLEN-1:0]  warp_local_o,
    output logic [XLEN-1:0]  warp_global_o,
    output logic [XLEN-1:0]  core_idx_o
);
    typedef logic [XLEN-1:0] word_t;

    localparam int THR_PER_CORE = THREADS * WARPS;

    word_t tid_w, wid_w, cid_w;
    word_t core_base_thr;

    always_comb begin
        tid_w         = word_t'(tid_i);
        wid_w         = word_t'(wid_i);
        cid_w         = word_t'(cid_i);
        core_base_thr = cid_w * word_t'(THR_PER_CORE);

        thr_in_warp_o = tid_w;
        thr_in_core_o = tid_w + wid_w * word_t'(THREADS);
        thr_global_o  = tid_w + wid_w * word_t'(THREADS) + core_base_thr;
        warp_local_o  = wid_w;
        warp_global_o = wid_w + cid_w * word_t'(WARPS);
        core_idx_o    = cid_w;
    end

endmodule

// File: rtl/csr_counters.sv
module csr_counters
    import csr_ident_pkg::*;
#(
    parameter logic [63:0] CYC_INIT = '0,
    parameter logic [63:0] RET_INIT = '0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        retire_i,
    output logic [63:0] cycle_o,
    output logic [63:0] instret_o
);
    ctr_state_t ctr_d, ctr_q;

    always_comb begin
        ctr_d       = ctr_q;
        ctr_d.cycle = ctr_q.cycle + 64'd1;
        if (retire_i) begin
            ctr_d.instret = ctr_q.instret + 64'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctr_q.cycle   <= CYC_INIT;
            ctr_q.instret <= RET_INIT;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign cycle_o   = ctr_q.cycle;
    assign instret_o = ctr_q.instret;

    // R6: the cycle count advances by exactly one per clock
    a_r6_cycle_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cycle_o == $past(cycle_o) + 64'd1);

    // R7: a retire pulse adds one to the retired count
    a_r7_retire_step: assert property (@(posedge clk) disable iff (!rst_n)
        retire_i |=> instret_o == $past(instret_o) + 64'd1);

    // R7: without a pulse the retired count holds
    a_r7_retire_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !retire_i |=> $stable(instret_o));

endmodule

// File: rtl/csr_gen_file.sv
module csr_gen_file #(
    parameter int XLEN  = 32,
    parameter int DEPTH = 16,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [IDX_W-1:0] widx_i,
    input  logic [XLEN-1:0]  wdata_i,
    input  logic [IDX_W-1:0] ridx_i,
    output logic [XLEN-1:0]  rdata_o
);
    typedef logic [DEPTH-1:0][XLEN-1:0] mem_t;

    mem_t mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (we_i) begin
            mem_d[widx_i] = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata_o = mem_q[ridx_i];

    // R8: a write lands in the addressed entry at the edge
    a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> mem_q[$past(widx_i)] == $past(wdata_i));

    // R8: no write strobe, no change anywhere in the array
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(mem_q));

endmodule

// File: rtl/csr_ident_unit.sv
module csr_ident_unit
    import csr_ident_pkg::*;
#(
    parameter int          XLEN      = 32,
    parameter int          THREADS   = 4,
    parameter int          WARPS     = 4,
    parameter int          NUM_CORES = 2,
    parameter int          GEN_DEPTH = 16,
    parameter logic [63:0] CYC_INIT  = '0,
    parameter logic [63:0] RET_INIT  = '0,
    localparam int         TID_W     = (THREADS   > 1) ? $clog2(THREADS)   : 1,
    localparam int         WID_W     = (WARPS     > 1) ? $clog2(WARPS)     : 1,
    localparam int         CID_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CID_W-1:0]  core_id_i,
    input  logic [CSR_AW-1:0] rd_addr_i,
    input  logic [TID_W-1:0]  rd_tid_i,
    input  logic [WID_W-1:0]  rd_wid_i,
    output logic [XLEN-1:0]   rd_data_o,
    input  logic              wr_en_i,
    input  logic [CSR_AW-1:0] wr_addr_i,
    input  logic [XLEN-1:0]   wr_data_i,
    input  logic              retire_i
);
    typedef logic [XLEN-1:0] word_t;

    localparam int GIDX_W = (GEN_DEPTH > 1) ? $clog2(GEN_DEPTH) : 1;

    csr_sel_e rd_sel, wr_sel;
    logic     gen_we;
    word_t    gen_rdata;
    word_t    id_thr_warp, id_thr_core, id_thr_glob;
    word_t    id_warp_loc, id_warp_glob, id_core;
    logic [63:0] cnt_cycle, cnt_instret;
    word_t    rd_d, rd_q;

    csr_id_calc #(
        .XLEN    (XLEN),
        .THREADS (THREADS),
        .WARPS   (WARPS),
        .TID_W   (TID_W),
        .WID_W   (WID_W),
        .CID_W   (CID_W)
    ) u_ids (
        .tid_i         (rd_tid_i),
        .wid_i         (rd_wid_i),
        .cid_i         (core_id_i),
        .thr_in_warp_o (id_thr_warp),
        .thr_in_core_o (id_thr_core),
        .thr_global_o  (id_thr_glob),
        .warp_local_o  (id_warp_loc),
        .warp_global_o (id_warp_glob),
        .core_idx_o    (id_core)
    );

    csr_counters #(
        .CYC_INIT (CYC_INIT),
        .RET_INIT (RET_INIT)
    ) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .retire_i  (retire_i),
        .cycle_o   (cnt_cycle),
        .instret_o (cnt_instret)
    );

    csr_gen_file #(
        .XLEN  (XLEN),
        .DEPTH (GEN_DEPTH),
        .IDX_W (GIDX_W)
    ) u_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (gen_we),
        .widx_i  (wr_addr_i[GIDX_W-1:0]),
        .wdata_i (wr_data_i),
        .ridx_i  (rd_addr_i[GIDX_W-1:0]),
        .rdata_o (gen_rdata)
    );

    always_comb begin
        rd_sel = csr_decode(rd_addr_i);
        wr_sel = csr_decode(wr_addr_i);
        gen_we = wr_en_i && (wr_sel == SEL_GENERIC);

        case (rd_sel)
            SEL_CYC_LO:      rd_d = word_t'(cnt_cycle[31:0]);
            SEL_CYC_HI:      rd_d = word_t'(cnt_cycle[63:32]);
            SEL_RET_LO:      rd_d = word_t'(cnt_instret[31:0]);
            SEL_RET_HI:      rd_d = word_t'(cnt_instret[63:32]);
            SEL_THR_IN_WARP: rd_d = id_thr_warp;
            SEL_THR_IN_CORE: rd_d = id_thr_core;
            SEL_THR_GLOBAL:  rd_d = id_thr_glob;
            SEL_WARP_LOCAL:  rd_d = id_warp_loc;
            SEL_WARP_GLOBAL: rd_d = id_warp_glob;
            SEL_CORE_IDX:    rd_d = id_core;
            SEL_CFG_THREADS: rd_d = word_t'(THREADS);
            SEL_CFG_WARPS:   rd_d = word_t'(WARPS);
            SEL_CFG_CORES:   rd_d = word_t'(NUM_CORES);
            default:         rd_d = gen_rdata;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_data_o = rd_q;

    // R2: thread-in-warp read returns the sampled tid one edge later
    a_r2_tid_echo: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_i == A_THR_IN_WARP) |=> rd_data_o == word_t'($past(rd_tid_i)));

    // R4: core index read follows the core number input
    a_r4_core_echo: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_i == A_CORE_IDX) |=> rd_data_o == word_t'($past(core_id_i)));

    // R5: thread-count constant
    a_r5_cfg_threads: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_i == A_CFG_THREADS) |=> rd_data_o == word_t'(THREADS));

    // R9: a write to a read-only address leaves the next read of it intact
    a_r9_ro_core: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == A_CFG_WARPS && rd_addr_i == A_CFG_WARPS)
        |=> rd_data_o == word_t'(WARPS));

endmodule

// File: tb/sim_csr_ident_unit.sv
`timescale 1ns/1ps
module sim_csr_ident_unit;

    localparam int          XLEN = 32;
    localparam int          T    = 4;
    localparam int          W    = 8;
    localparam int          C    = 4;
    localparam int          GD   = 16;
    localparam logic [63:0] CYC0 = 64'h0000_0000_FFFF_FFF0;
    localparam logic [63:0] RET0 = 64'h0000_0000_FFFF_FFFE;
    localparam int          CID  = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  core_id_i = 2'(CID);
    logic [11:0] rd_addr_i = '0;
    logic [1:0]  rd_tid_i = '0;
    logic [2:0]  rd_wid_i = '0;
    logic [31:0] rd_data_o;
    logic        wr_en_i = 1'b0;
    logic [11:0] wr_addr_i = '0;
    logic [31:0] wr_data_i = '0;
    logic        retire_i = 1'b0;

    always #2.5 clk = ~clk;

    csr_ident_unit #(
        .XLEN(XLEN), .THREADS(T), .WARPS(W), .NUM_CORES(C), .GEN_DEPTH(GD),
        .CYC_INIT(CYC0), .RET_INIT(RET0)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .core_id_i(core_id_i),
        .rd_addr_i(rd_addr_i), .rd_tid_i(rd_tid_i), .rd_wid_i(rd_wid_i),
        .rd_data_o(rd_data_o), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i), .retire_i(retire_i)
    );

    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
        logic [11:0] addr;
    } item_t;
    item_t sb[$];

    logic [63:0] m_cyc, m_ret;
    logic [31:0] gen_m [GD];

    // reference counters from R6 and R7
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cyc <= CYC0;
            m_ret <= RET0;
        end else begin
            m_cyc <= m_cyc + 64'd1;
            if (retire_i) m_ret <= m_ret + 64'd1;
        end
    end

    function automatic bit is_ro(input logic [11:0] a);
        case (a)
            12'hC00, 12'hC02, 12'hC80, 12'hC82,
            12'hCC0, 12'hCC1, 12'hCC2, 12'hCC3, 12'hCC4, 12'hCC5,
            12'hFC0, 12'hFC1, 12'hFC2: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] model_read(input logic [11:0] a, input int tid, input int wid);
        case (a)
            12'hCC0: return 32'(tid);
            12'hCC1: return 32'(tid + wid * T);
            12'hCC2: return 32'(tid + wid * T + T * W * CID);
            12'hCC3: return 32'(wid);
            12'hCC4: return 32'(wid + W * CID);
            12'hCC5: return 32'(CID);
            12'hFC0: return 32'(T);
            12'hFC1: return 32'(W);
            12'hFC2: return 32'(C);
            12'hC00: return m_cyc[31:0];
            12'hC80: return m_cyc[63:32];
            12'hC02: return m_ret[31:0];
            12'hC82: return m_ret[63:32];
            default: return gen_m[int'(a) % GD];
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: one cycle of stimulus, expected read value pushed to the scoreboard
    task automatic step(input string tag, input logic [11:0] ra, input int tid = 0, input int wid = 0,
                        input bit wr = 1'b0, input logic [11:0] wa = '0, input logic [31:0] wd = '0,
                        input bit ret = 1'b0, input bit rd = 1'b1);
        item_t it;
        @(negedge clk);
        rd_addr_i = ra;
        rd_tid_i  = 2'(tid);
        rd_wid_i  = 3'(wid);
        wr_en_i   = wr;
        wr_addr_i = wa;
        wr_data_i = wd;
        retire_i  = ret;
        if (rd) begin
            it.exp  = model_read(ra, tid, wid);
            it.tag  = tag;
            it.addr = ra;
            sb.push_back(it);
        end
        if (wr && !is_ro(wa)) gen_m[int'(wa) % GD] = wd;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step("idle", 12'h000, 0, 0, 1'b0, '0, '0, 1'b0, 1'b0);
    endtask

    // monitor: compare after each edge
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            check(rd_data_o == it.exp, $sformatf("%s addr=%h", it.tag, it.addr), rd_data_o, it.exp);
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        for (int i = 0; i < GD; i++) gen_m[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        check(rd_data_o == 32'd0, "R1 read data in reset", rd_data_o, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset contents
        step("R1 general entry after reset", 12'h005);
        step("R1 R6 cycle start", 12'hC00);
        step("R1 R7 retired start", 12'hC02);

        // R2 thread index within warp
        for (int t = 0; t < T; t++) step("R2 thread in warp", 12'hCC0, t, 5);

        // R3 thread IDs at core and processor scope
        step("R3 thread in core", 12'hCC1, 1, 2);
        step("R3 thread in core", 12'hCC1, 3, 7);
        step("R3 global thread", 12'hCC2, 0, 0);
        step("R3 global thread", 12'hCC2, 3, 7);
        step("R3 global thread", 12'hCC2, 2, 4);

        // R4 warp and core identity
        step("R4 local warp", 12'hCC3, 1, 6);
        step("R4 global warp", 12'hCC4, 0, 5);
        step("R4 global warp", 12'hCC4, 3, 0);
        step("R4 core index", 12'hCC5, 2, 2);

        // R5 configuration constants
        step("R5 threads", 12'hFC0);
        step("R5 warps", 12'hFC1);
        step("R5 cores", 12'hFC2);

        // R6 cycle counter and carry into the upper half
        step("R6 cycle low", 12'hC00);
        step("R6 cycle low next", 12'hC00);
        idle(20);
        step("R6 cycle low after wrap", 12'hC00);
        step("R6 cycle high after wrap", 12'hC80);

        // R7 retired counter, pulses with same-cycle reads
        step("R7 retired low with pulse", 12'hC02, 0, 0, 1'b0, '0, '0, 1'b1);
        step("R7 retired low with pulse", 12'hC02, 0, 0, 1'b0, '0, '0, 1'b1);
        step("R7 retired high with pulse", 12'hC82, 0, 0, 1'b0, '0, '0, 1'b1);
        step("R7 retired low after", 12'hC02);
        step("R7 retired high after", 12'hC82);
        step("R7 retired hold", 12'hC02);

        // R8 general array
        step("R8 same-cycle read old", 12'h010, 0, 0, 1'b1, 12'h010, 32'hA5A5_0001);
        step("R8 read new", 12'h010);
        step("R8 write aliased index 7", 12'h123, 0, 0, 1'b1, 12'h3A7, 32'h1234_5678);
        step("R8 read alias of index 7", 12'h007);
        step("R8 read other alias", 12'h117);

        // R9 writes to read-only addresses
        step("R9 write thread id", 12'h123, 0, 0, 1'b1, 12'hCC0, 32'hFFFF_FFFF);
        step("R9 thread id intact", 12'hCC0, 2, 1);
        step("R9 general index 0 intact", 12'h000);
        step("R9 write cycle low", 12'hC02, 0, 0, 1'b1, 12'hC00, 32'h0);
        step("R9 cycle low intact", 12'hC00);
        step("R9 write warps cfg with read", 12'hFC1, 0, 0, 1'b1, 12'hFC1, 32'h55);
        step("R9 warps cfg intact", 12'hFC1);
        step("R9 general index 1 intact", 12'h001);

        idle(3);
        finish_run();
    end

endmodule